// File: doc/BRIEF.md
# Time-Shared Gaussian Pyramid Engine

This block turns a raster stream of 8-bit pixels into the two reduced levels of a three-level Gaussian pyramid. Every reduced pixel is computed by one shared 3x3 smoothing unit. That unit serves all levels in turn on a fixed rotation of slots. Each level that feeds a coarser one has its own pair of row stores and its own window registers. A selector hands the window of the level that owns the current slot to the shared unit.

Each level is made by smoothing the finer level with the binomial kernel [1 2 1] x [1 2 1]. The sum is divided by 16 with rounding half up. Only the pixels at even row and even column are kept. Reduced pixels of the middle level leave the block on the output stream and are also written back into that level's own row stores. From there they feed the coarsest level. Only the source image comes in, and nothing but tagged reduced pixels goes out.

The source enters through a valid/ready handshake. The ready signal is raised only in source slots, and only while the finest level has no unserved window. Each output pixel carries a level tag. Within one level, output pixels appear in raster order.

Top module: `gp_pyramid_engine`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, out_valid_o and pix_ready_o are both low.
- R2: The slot rotation is 21 cycles long: 1 slot for level 2, then 4 slots for level 1, then 16 slots for level 0, and then it repeats. With no pending work, pix_ready_o is low for the first 5 cycles of each rotation and high for the other 16.
- R3: Each level-1 pixel (i,j) equals (S + 8) >> 4, where S is the sum of the source pixels at rows 2i-1..2i+1 and columns 2j-1..2j+1, weighted 1,2,1 along each axis.
- R4: Each level-2 pixel is formed from the level-1 image by the same rule as in R3. It is emitted with out_level_o = 2.
- R5: A window row or column with index -1 takes the value of row 0 or column 0.
- R6: Division by 16 rounds half up. A weighted sum of 8 gives 1, and a sum of 7 gives 0.
- R7: A source pixel is taken only in a cycle where pix_valid_i and pix_ready_o are both high. pix_i is ignored in every other cycle.
- R8: Level-1 pixels carry out_level_o = 1 and level-2 pixels carry out_level_o = 2. Each level is emitted in raster order. Each frame yields exactly (W/2)(H/2) level-1 pixels and (W/4)(H/4) level-2 pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_i | input | 8 | Source pixel, raster order |
| pix_valid_i | input | 1 | Source pixel valid |
| pix_ready_o | output | 1 | Source pixel accepted in this cycle if valid |
| out_pix_o | output | 8 | Reduced pixel |
| out_valid_o | output | 1 | out_pix_o holds a reduced pixel |
| out_level_o | output | 2 | Pyramid level of out_pix_o (1 or 2) |

## Verification
The bench computes both reduced levels arithmetically, compares every output pixel in arrival order, and counts the pixels of each level per frame.

- An impulse frame exposes rounding by truncation, because the expected values of 1 would come out as 0.
- A bright top row and left column expose wrong edge handling, because zero padding or a shifted window would change the border pixels.
- A frame with gaps, which drives 0xFF while valid is low, catches a design that takes pix_i outside a handshake, because that corrupts later windows.
- An unwatched overrun of a pending window would drop pixels and show up as a count mismatch.
- After reset, the ready pattern shows whether the slot rotation has the right order and the right slot counts.

// File: rtl/gp_pkg.sv
package gp_pkg;
  localparam int PIX_W = 8;
  typedef logic [PIX_W-1:0] pix_t;
  typedef pix_t [2:0] col_t;        // [row]
  typedef pix_t [2:0][2:0] win_t;   // [row][col]

  // slots per rotation owned by a level: coarsest gets 1, each finer one 4x more
  function automatic int slots_for(input int lvl, input int levels);
    return 1 << (2 * (levels - 1 - lvl));
  endfunction

  // first slot of a level: coarser levels come first in the rotation
  function automatic int slot_base(input int lvl, input int levels);
    int b = 0;
    for (int k = lvl + 1; k < levels; k++) b += slots_for(k, levels);
    return b;
  endfunction

  function automatic int rot_len(input int levels);
    int n = 0;
    for (int k = 0; k < levels; k++) n += slots_for(k, levels);
    return n;
  endfunction
endpackage

// File: rtl/gp_slot_sched.sv
module gp_slot_sched
  import gp_pkg::*;
#(
  parameter int LEVELS = 3,
  parameter int LVL_W  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [LVL_W-1:0] slot_lvl_o
);
  localparam int ROT = rot_len(LEVELS);
  localparam int CW  = $clog2(ROT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (cnt_q == CW'(ROT - 1)) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  always_comb begin
    slot_lvl_o = '0;
    for (int l = 0; l < LEVELS; l++) begin
      if (int'(cnt_q) >= slot_base(l, LEVELS) &&
          int'(cnt_q) <  slot_base(l, LEVELS) + slots_for(l, LEVELS))
        slot_lvl_o = LVL_W'(l);
    end
  end

  AST_SLOT_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_lvl_o != $past(slot_lvl_o)) |->
      ((slot_lvl_o == $past(slot_lvl_o) - 1'b1) ||
       ($past(slot_lvl_o) == '0 && slot_lvl_o == LVL_W'(LEVELS - 1)))); // R2
endmodule

// File: rtl/gp_level_buf.sv
module gp_level_buf
  import gp_pkg::*;
#(
  parameter int W = 16,
  parameter int H = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ingest_i,
  input  pix_t pix_i,
  input  logic take_i,
  output win_t win_o,
  output logic win_vld_o
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam int RW = (H > 1) ? $clog2(H) : 1;

  logic [CW-1:0] col_q;
  logic [RW-1:0] row_q;
  pix_t lb_a [W];  // previous row
  pix_t lb_b [W];  // row before that
  col_t col_m1_q, col_m2_q, colvec;
  logic done_w;

  always_comb begin
    colvec[0] = (row_q == RW'(1)) ? lb_a[col_q] : lb_b[col_q];  // top edge replicate
    colvec[1] = lb_a[col_q];
    colvec[2] = pix_i;
  end

  assign done_w = ingest_i & row_q[0] & col_q[0];

  always_ff @(posedge clk_i) begin
    if (ingest_i) begin
      lb_b[col_q] <= lb_a[col_q];
      lb_a[col_q] <= pix_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q     <= '0;
      row_q     <= '0;
      col_m1_q  <= '0;
      col_m2_q  <= '0;
      win_o     <= '0;
      win_vld_o <= 1'b0;
    end else begin
      if (ingest_i) begin
        col_m2_q <= col_m1_q;
        col_m1_q <= colvec;
        if (col_q == CW'(W - 1)) begin
          col_q <= '0;
          row_q <= (row_q == RW'(H - 1)) ? '0 : row_q + 1'b1;
        end else begin
          col_q <= col_q + 1'b1;
        end
      end
      if (done_w) begin
        for (int r = 0; r < 3; r++) begin
          win_o[r][0] <= (col_q == CW'(1)) ? col_m1_q[r] : col_m2_q[r];  // left edge replicate
          win_o[r][1] <= col_m1_q[r];
          win_o[r][2] <= colvec[r];
        end
        win_vld_o <= 1'b1;
      end else if (take_i) begin
        win_vld_o <= 1'b0;
      end
    end
  end

  AST_NO_PEND_OVERRUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_w |-> (!win_vld_o || take_i)); // R8
endmodule

// File: rtl/gp_conv_pe.sv
module gp_conv_pe
  import gp_pkg::*;
#(
  parameter int LVL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  win_t             win_i,
  input  logic             vld_i,
  input  logic [LVL_W-1:0] lvl_i,
  output pix_t             pix_o,
  output logic             vld_o,
  output logic [LVL_W-1:0] lvl_o
);
  localparam int ACC_W = PIX_W + 4;

  logic [ACC_W-1:0] acc, rnd;

  always_comb begin
    acc = '0;
    for (int r = 0; r < 3; r++)
      for (int c = 0; c < 3; c++)
        acc += ACC_W'(win_i[r][c]) << (((r == 1) ? 1 : 0) + ((c == 1) ? 1 : 0));
    rnd = (acc + ACC_W'(8)) >> 4;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_o <= '0;
      vld_o <= 1'b0;
      lvl_o <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) begin
        pix_o <= rnd[PIX_W-1:0];
        lvl_o <= lvl_i;
      end
    end
  end
endmodule

// File: rtl/gp_pyramid_engine.sv
module gp_pyramid_engine
  import gp_pkg::*;
#(
  parameter int IMG_W  = 16,
  parameter int IMG_H  = 16,
  parameter int LEVELS = 3,
  localparam int LVL_W = $clog2(LEVELS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [7:0]       pix_i,
  input  logic             pix_valid_i,
  output logic             pix_ready_o,
  output logic [7:0]       out_pix_o,
  output logic             out_valid_o,
  output logic [LVL_W-1:0] out_level_o
);
  localparam int NBUF = LEVELS - 1;

  logic [LVL_W-1:0] slot_lvl;
  win_t             win_s [NBUF];
  logic [LEVELS-1:0] pend_v;
  win_t             pe_win;
  logic             pe_fire;

  gp_slot_sched #(.LEVELS(LEVELS), .LVL_W(LVL_W)) u_sched (
    .clk_i, .rst_ni, .slot_lvl_o(slot_lvl)
  );

  assign pend_v[LEVELS-1] = 1'b0;
  assign pix_ready_o = (slot_lvl == '0) && !pend_v[0];

  for (genvar l = 0; l < NBUF; l++) begin : g_lvl
    logic ingest;
    pix_t din;
    if (l == 0) begin : g_src
      assign ingest = pix_ready_o & pix_valid_i;
      assign din    = pix_i;
    end else begin : g_fb
      assign ingest = out_valid_o && (out_level_o == LVL_W'(l));
      assign din    = out_pix_o;
    end
    gp_level_buf #(.W(IMG_W >> l), .H(IMG_H >> l)) u_buf (
      .clk_i, .rst_ni,
      .ingest_i (ingest),
      .pix_i    (din),
      .take_i   (pe_fire && (slot_lvl == LVL_W'(l + 1))),
      .win_o    (win_s[l]),
      .win_vld_o(pend_v[l])
    );
  end

  // timing mux: slot s filters the window of level s-1; wait if level s still holds an unserved window
  always_comb begin
    pe_fire = 1'b0;
    pe_win  = '0;
    for (int s = 1; s < LEVELS; s++) begin
      if (slot_lvl == LVL_W'(s)) begin
        pe_win  = win_s[s-1];
        pe_fire = pend_v[s-1] && !pend_v[s];
      end
    end
  end

  gp_conv_pe #(.LVL_W(LVL_W)) u_pe (
    .clk_i, .rst_ni,
    .win_i(pe_win),
    .vld_i(pe_fire),
    .lvl_i(slot_lvl),
    .pix_o(out_pix_o),
    .vld_o(out_valid_o),
    .lvl_o(out_level_o)
  );

  AST_OUT_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (out_level_o != '0 && int'(out_level_o) < LEVELS)); // R8
  AST_RESULT_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> ($past(slot_lvl) == out_level_o)); // R2
endmodule

// File: tb/gp_pyramid_engine_tb.sv
`timescale 1ns/1ps
module gp_pyramid_engine_tb;
  localparam int W = 16, H = 16;
  localparam int N1 = (W/2)*(H/2), N2 = (W/4)*(H/4);

  logic clk = 0, rst_n = 0;
  logic [7:0] pix = 0;
  logic vld = 0;
  logic rdy, ovld;
  logic [7:0] opix;
  logic [1:0] olvl;

  always #2.5 clk = ~clk;

  gp_pyramid_engine #(.IMG_W(W), .IMG_H(H), .LEVELS(3)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pix_i(pix), .pix_valid_i(vld), .pix_ready_o(rdy),
    .out_pix_o(opix), .out_valid_o(ovld), .out_level_o(olvl)
  );

  int checks = 0, fails = 0;
  int g0 [H][W];
  int g1 [H/2][W/2];
  int e1 [N1];
  int e2 [N2];
  int n1 = 0, n2 = 0;
  string tag1 = "R3", tag2 = "R4";

  function automatic void chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s got %0d expected %0d", req, what, act, exp);
    end
  endfunction

  function automatic int cl(input int v, input int mx);
    return (v < 0) ? 0 : ((v > mx) ? mx : v);
  endfunction

  task automatic build_model();
    for (int i = 0; i < H/2; i++)
      for (int j = 0; j < W/2; j++) begin
        int s = 0;
        for (int dr = -1; dr <= 1; dr++)
          for (int dc = -1; dc <= 1; dc++)
            s += g0[cl(2*i+dr, H-1)][cl(2*j+dc, W-1)] * (dr == 0 ? 2 : 1) * (dc == 0 ? 2 : 1);
        g1[i][j] = (s + 8) / 16;
        e1[i*(W/2)+j] = g1[i][j];
      end
    for (int i = 0; i < H/4; i++)
      for (int j = 0; j < W/4; j++) begin
        int s = 0;
        for (int dr = -1; dr <= 1; dr++)
          for (int dc = -1; dc <= 1; dc++)
            s += g1[cl(2*i+dr, H/2-1)][cl(2*j+dc, W/2-1)] * (dr == 0 ? 2 : 1) * (dc == 0 ? 2 : 1);
        e2[i*(W/4)+j] = (s + 8) / 16;
      end
  endtask

  // monitor: compare every output with the model in arrival order (R8 raster order)
  always @(negedge clk) begin
    if (rst_n && ovld) begin
      if (olvl == 2'd1) begin
        if (n1 < N1) chk(opix == e1[n1][7:0], tag1, $sformatf("level1 #%0d", n1), opix, e1[n1]);
        else chk(0, "R8", "extra level1 pixel", n1, N1);
        n1++;
      end else if (olvl == 2'd2) begin
        if (n2 < N2) chk(opix == e2[n2][7:0], tag2, $sformatf("level2 #%0d", n2), opix, e2[n2]);
        else chk(0, "R8", "extra level2 pixel", n2, N2);
        n2++;
      end else begin
        chk(0, "R8", "bad level tag", olvl, 1);
      end
    end
  end

  task automatic send_pix(input logic [7:0] p);
    @(negedge clk);
    pix = p; vld = 1;
    while (!rdy) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      vld = 0; pix = 8'hFF;   // R7 garbage while not valid
    end
  endtask

  task automatic run_frame(input int mode, input bit gaps, input string t1, input string t2);
    for (int r = 0; r < H; r++)
      for (int c = 0; c < W; c++)
        case (mode)
          0: g0[r][c] = (r*16 + c*7) & 255;
          1: g0[r][c] = (r*37 + c*101 + r*c*13) % 256;
          2: g0[r][c] = (r == 0 || c == 0) ? 200 : 0;
          3: g0[r][c] = (r == 1 && c == 1) ? 8 : 0;
          default: g0[r][c] = 255;
        endcase
    build_model();
    tag1 = t1; tag2 = t2;
    n1 = 0; n2 = 0;
    for (int r = 0; r < H; r++)
      for (int c = 0; c < W; c++) begin
        if (gaps && ((r*W + c) % 5 == 0)) idle((r + c) % 3 + 1);
        send_pix(g0[r][c][7:0]);
      end
    idle(300);
    chk(n1 == N1, "R8", "level1 count", n1, N1);
    chk(n2 == N2, "R8", "level2 count", n2, N2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(ovld == 0, "R1", "out_valid in reset", ovld, 0);
    chk(rdy == 0, "R1", "ready in reset", rdy, 0);
    rst_n = 1;
    #1;
    chk(ovld == 0 && rdy == 0, "R1", "first cycle after reset", {ovld, rdy}, 0);
    for (int k = 0; k < 42; k++) begin
      if (k > 0) begin @(negedge clk); #1; end
      chk(rdy == ((k % 21) >= 5), "R2", $sformatf("ready in slot %0d", k % 21), rdy, (k % 21) >= 5);
    end
    run_frame(0, 0, "R3", "R4");
    run_frame(1, 1, "R7", "R7");
    run_frame(2, 0, "R5", "R5");
    run_frame(3, 1, "R6", "R4");
    run_frame(4, 0, "R3", "R4");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule